// File: doc/BRIEF.md
# Multi-Channel Prescaled Timer Unit

A memory-mapped timer peripheral. A single shared prescaler divides the system clock into a common tick. A parameterised number of 32-bit down-counting channels, from one to eight, consume that tick. Software programs the block through a plain word-addressed register port, with address, write enable, write data and combinational read data. Each channel drives its own interrupt line.

A channel counts the shared tick down from a programmed value. When the count passes below zero (underflow), the channel can latch a sticky pending flag and emit a one-cycle interrupt pulse. It then either reloads and keeps running, or stops. Software restarts a channel in one of two ways: it writes the counter directly, or it sets a write-only load bit in the channel's config register, which copies the channel's reload value into the counter.

Top module: `prescaled_timer_unit`

## Requirements
- R1: Word address bits [5:2] select a block: block 0 is the unit, block n+1 is channel n. Bits [1:0] select a word in the block. In the unit: word 0 is the scaler value, word 1 is the scaler reload, word 2 is the unit config. In a channel: word 0 is the counter, word 1 is the reload, word 2 is the config.
- R2: The scaler value and scaler reload hold 16 bits, and written bits above bit 15 are dropped. The scaler value counts down once per clock. While it is 0, a tick is issued and the value reloads from the scaler reload on the next clock. The tick therefore repeats every (scaler reload + 1) clocks.
- R3: An enabled channel decrements once per tick. A disabled channel holds its counter.
- R4: A channel loaded with N underflows on its (N+1)th tick. With restart (config bit 1) set, the counter then takes the channel reload value and counting continues.
- R5: On an underflow with restart clear, the counter becomes all ones and the enable bit (config bit 0) clears.
- R6: On an underflow with interrupt enable (config bit 3) set, the pending bit (config bit 4) sets and the channel's interrupt output is high for exactly the next clock cycle. With interrupt enable clear, neither happens.
- R7: A config write with bit 4 = 1 clears pending. A write with bit 4 = 0 keeps it. Only an underflow sets pending, and an underflow wins over a clear in the same cycle.
- R8: A config write with the load bit (bit 2) set copies the reload value into the counter. A counter write sets the count directly. Either write takes the place of that cycle's count.
- R9: A channel config reads enable in bit 0, restart in bit 1, interrupt enable in bit 3 and pending in bit 4. All other bits, including the load bit, read 0.
- R10: The unit config reads the channel count modulo 8 in bits [2:0], the base interrupt number in bits [7:3], and ones in bits 8 and 9. Writes to it are ignored. With the defaults (2 channels, base 8) it reads 0x342.
- R11: Reads of unit word 3, or of any block at or above channel count + 1, return 0. Writes there change no state.
- R12: Reset clears the scaler value, the scaler reload, and every channel's counter, reload and config to zero, and holds all interrupt outputs low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W (6) | Word address |
| we_i | input | 1 | Write enable for the addressed word |
| wdata_i | input | DW (32) | Write data |
| rdata_o | output | DW (32) | Read data of the addressed word, combinational |
| irq_o | output | NUM_CH | One interrupt pulse line per channel |

## Verification
The bench aims at the off-by-one at underflow. A design that fires at zero instead of below it would pulse one tick early in every period, and the model catches that pulse in the wrong cycle. It checks pending write semantics: a design that treats bit 4 as plain data would either clear pending on a write of zero or set it on a write of one. It checks one-shot termination, where a wrong design would keep counting through all ones or leave enable set. It also covers scaler truncation and tick period, load-bit readback, and the read-only and out-of-range addresses. A final random phase mixes writes with running counters, so a write and an underflow land in the same cycle and the priority rules are exercised.

// File: rtl/ptu_pkg.sv
package ptu_pkg;

   // channel config bit positions (software-visible encoding)
   localparam int unsigned CFG_EN = 0;
   localparam int unsigned CFG_RS = 1;
   localparam int unsigned CFG_LD = 2;
   localparam int unsigned CFG_IE = 3;
   localparam int unsigned CFG_IP = 4;

   // word selects inside a block
   localparam logic [1:0] W_UNIT_SCL = 2'd0;
   localparam logic [1:0] W_UNIT_SRL = 2'd1;
   localparam logic [1:0] W_UNIT_CFG = 2'd2;
   localparam logic [1:0] W_CH_CNT   = 2'd0;
   localparam logic [1:0] W_CH_RLD   = 2'd1;
   localparam logic [1:0] W_CH_CFG   = 2'd2;

   typedef struct packed {
      logic cnt_we;
      logic rld_we;
      logic cfg_we;
   } ch_wr_t;

endpackage

// File: rtl/ptu_prescaler.sv
module ptu_prescaler #(
   parameter int unsigned PRE_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             val_we,
   input  logic             rld_we,
   input  logic [PRE_W-1:0] wdata,
   output logic [PRE_W-1:0] val_o,
   output logic [PRE_W-1:0] rld_o,
   output logic             tick_o
);

   logic [PRE_W-1:0] val_q;
   logic [PRE_W-1:0] rld_q;

   assign tick_o = (val_q == '0);
   assign val_o  = val_q;
   assign rld_o  = rld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val_q <= '0;
         rld_q <= '0;
      end else begin
         if (rld_we) rld_q <= wdata;
         if (val_we)          val_q <= wdata;
         else if (tick_o)     val_q <= rld_q;
         else                 val_q <= val_q - 1'b1;
      end
   end

   // R2: after a tick the value takes the reload
   a_r2_reload_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (val_q == '0 && !val_we) |=> (val_q == $past(rld_q)));

   // R2: between ticks the value steps down by one
   a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (val_q != '0 && !val_we) |=> (val_q == $past(val_q) - 1'b1));

endmodule

// File: rtl/ptu_channel.sv
module ptu_channel
   import ptu_pkg::*;
#(
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  ch_wr_t        wr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] cnt_o,
   output logic [DW-1:0] rld_o,
   output logic [DW-1:0] cfg_o,
   output logic          irq_o
);

   logic [DW-1:0] cnt_q, rld_q;
   logic          en_q, rs_q, ie_q, ip_q, irq_q;
   logic          uflow, load;

   assign uflow = en_q && tick && (cnt_q == '0);
   assign load  = wr.cfg_we && wdata[CFG_LD];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         rld_q <= '0;
         en_q  <= 1'b0;
         rs_q  <= 1'b0;
         ie_q  <= 1'b0;
         ip_q  <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         if (wr.rld_we) rld_q <= wdata;

         if (wr.cnt_we)              cnt_q <= wdata;
         else if (load)              cnt_q <= rld_q;
         else if (en_q && tick) begin
            if (cnt_q == '0)         cnt_q <= rs_q ? rld_q : '1;
            else                     cnt_q <= cnt_q - 1'b1;
         end

         if (wr.cfg_we) begin
            en_q <= wdata[CFG_EN];
            rs_q <= wdata[CFG_RS];
            ie_q <= wdata[CFG_IE];
         end else if (uflow && !rs_q) begin
            en_q <= 1'b0;
         end

         if (uflow && ie_q)                    ip_q <= 1'b1;
         else if (wr.cfg_we && wdata[CFG_IP])  ip_q <= 1'b0;

         irq_q <= uflow && ie_q;
      end
   end

   always_comb begin
      cfg_o         = '0;
      cfg_o[CFG_EN] = en_q;
      cfg_o[CFG_RS] = rs_q;
      cfg_o[CFG_IE] = ie_q;
      cfg_o[CFG_IP] = ip_q;
   end

   assign cnt_o = cnt_q;
   assign rld_o = rld_q;
   assign irq_o = irq_q;

   // R3: a disabled channel with no write holds its count
   a_r3_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !wr.cnt_we && !load) |=> (cnt_q == $past(cnt_q)));

   // R4: restart underflow reloads the counter
   a_r4_restart_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (uflow && rs_q && !wr.cnt_we && !load) |=> (cnt_q == $past(rld_q)));

   // R5: one-shot underflow stops the channel at all ones
   a_r5_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (uflow && !rs_q && !wr.cnt_we && !wr.cfg_we) |=> (!en_q && cnt_q == '1));

   // R6: an interrupt pulse is always accompanied by pending
   a_r6_irq_pending: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> ip_q);

   // R7: pending only rises together with an interrupt pulse
   a_r7_pending_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ip_q) |-> irq_q);

   // R8: a load write copies the reload value
   a_r8_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !wr.cnt_we) |=> (cnt_q == $past(rld_q)));

endmodule

// File: rtl/prescaled_timer_unit.sv
module prescaled_timer_unit
   import ptu_pkg::*;
#(
   parameter int unsigned NUM_CH   = 2,
   parameter int unsigned IRQ_BASE = 8,
   parameter int unsigned PRE_W    = 16,
   parameter int unsigned DW       = 32,
   parameter int unsigned ADDR_W   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              we_i,
   input  logic [DW-1:0]     wdata_i,
   output logic [DW-1:0]     rdata_o,
   output logic [NUM_CH-1:0] irq_o
);

   localparam int unsigned BLK_W = ADDR_W - 2;
   localparam int unsigned PAD_W = DW - PRE_W;
   localparam logic [DW-1:0] UNIT_CFG =
      {{(DW-10){1'b0}}, 2'b11, 5'(IRQ_BASE), 3'(NUM_CH)};

   if (NUM_CH < 1 || NUM_CH > 8) begin : g_bad_num_ch
      $error("NUM_CH must lie in 1..8");
   end
   if (ADDR_W < 6) begin : g_bad_addr_w
      $error("ADDR_W too small for the register map");
   end
   if (PRE_W >= DW || DW < 10) begin : g_bad_widths
      $error("PRE_W must be narrower than DW, DW at least 10");
   end
   if (IRQ_BASE > 31) begin : g_bad_irq_base
      $error("IRQ_BASE must fit in 5 bits");
   end

   logic [BLK_W-1:0] blk;
   logic [1:0]       sub;
   logic             unit_sel;

   assign blk      = addr_i[ADDR_W-1:2];
   assign sub      = addr_i[1:0];
   assign unit_sel = (blk == '0);

   // ---------------- shared prescaler ----------------
   logic [PRE_W-1:0] scl_val, scl_rld;
   logic             tick;

   ptu_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .val_we (we_i && unit_sel && sub == W_UNIT_SCL),
      .rld_we (we_i && unit_sel && sub == W_UNIT_SRL),
      .wdata  (wdata_i[PRE_W-1:0]),
      .val_o  (scl_val),
      .rld_o  (scl_rld),
      .tick_o (tick)
   );

   // ---------------- channels ----------------
   logic [DW-1:0]     ch_cnt [NUM_CH];
   logic [DW-1:0]     ch_rld [NUM_CH];
   logic [DW-1:0]     ch_cfg [NUM_CH];
   logic [NUM_CH-1:0] ch_sel;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      ch_wr_t wr;

      assign ch_sel[i]  = (blk == BLK_W'(i + 1));
      assign wr.cnt_we  = we_i && ch_sel[i] && sub == W_CH_CNT;
      assign wr.rld_we  = we_i && ch_sel[i] && sub == W_CH_RLD;
      assign wr.cfg_we  = we_i && ch_sel[i] && sub == W_CH_CFG;

      ptu_channel #(.DW(DW)) u_ch (
         .clk   (clk),
         .rst_n (rst_n),
         .tick  (tick),
         .wr    (wr),
         .wdata (wdata_i),
         .cnt_o (ch_cnt[i]),
         .rld_o (ch_rld[i]),
         .cfg_o (ch_cfg[i]),
         .irq_o (irq_o[i])
      );
   end

   // ---------------- read mux ----------------
   always_comb begin
      rdata_o = '0;
      if (unit_sel) begin
         case (sub)
            W_UNIT_SCL: rdata_o = {{PAD_W{1'b0}}, scl_val};
            W_UNIT_SRL: rdata_o = {{PAD_W{1'b0}}, scl_rld};
            W_UNIT_CFG: rdata_o = UNIT_CFG;
            default:    rdata_o = '0;
         endcase
      end else begin
         for (int k = 0; k < NUM_CH; k++) begin
            if (ch_sel[k]) begin
               case (sub)
                  W_CH_CNT: rdata_o = ch_cnt[k];
                  W_CH_RLD: rdata_o = ch_rld[k];
                  W_CH_CFG: rdata_o = ch_cfg[k];
                  default:  rdata_o = '0;
               endcase
            end
         end
      end
   end

   // R11: unmapped addresses read as zero
   a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ((!unit_sel && ch_sel == '0) || sub == 2'd3) |-> (rdata_o == '0));

   // R10: the capability word never changes
   a_r10_unit_cfg_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (unit_sel && sub == W_UNIT_CFG) |-> (rdata_o == UNIT_CFG));

   // R12: interrupts stay quiet in the first cycle after reset
   a_r12_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (irq_o == '0));

endmodule

// File: tb/prescaled_timer_unit_bench.sv
module prescaled_timer_unit_bench;

   localparam int NC = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [5:0]    addr = '0;
   logic          we = 1'b0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [NC-1:0] irq;

   int vectors = 0;
   int fails = 0;
   bit started = 0;
   string cur_req = "R12";

   always #5 clk = ~clk;

   prescaled_timer_unit u_prescaled_timer_unit (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr_i  (addr),
      .we_i    (we),
      .wdata_i (wdata),
      .rdata_o (rdata),
      .irq_o   (irq)
   );

   // ---------------- behavioural reference ----------------
   logic [15:0] m_sc = 0, m_srl = 0;
   logic [31:0] m_cnt [NC];
   logic [31:0] m_rld [NC];
   bit          m_en [NC], m_rs [NC], m_ie [NC], m_ip [NC], m_irq [NC];

   initial for (int i = 0; i < NC; i++) begin
      m_cnt[i] = 0; m_rld[i] = 0;
      m_en[i] = 0; m_rs[i] = 0; m_ie[i] = 0; m_ip[i] = 0; m_irq[i] = 0;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         m_sc = 0; m_srl = 0;
         for (int i = 0; i < NC; i++) begin
            m_cnt[i] = 0; m_rld[i] = 0;
            m_en[i] = 0; m_rs[i] = 0; m_ie[i] = 0; m_ip[i] = 0; m_irq[i] = 0;
         end
      end else begin
         bit t;
         int b, s;
         t = (m_sc == 0);
         b = addr >> 2;
         s = addr & 3;
         for (int i = 0; i < NC; i++) begin
            bit hit, uf, ld;
            logic [31:0] oldr;
            hit  = we && (b == i + 1);
            uf   = m_en[i] && t && (m_cnt[i] == 0);
            ld   = hit && s == 2 && wdata[2];
            oldr = m_rld[i];
            m_irq[i] = uf && m_ie[i];
            if (hit && s == 0)        m_cnt[i] = wdata;
            else if (ld)              m_cnt[i] = oldr;
            else if (m_en[i] && t)    m_cnt[i] = (m_cnt[i] == 0) ? (m_rs[i] ? oldr : 32'hFFFF_FFFF)
                                                                  : m_cnt[i] - 1;
            if (hit && s == 1) m_rld[i] = wdata;
            if (uf && m_ie[i])                    m_ip[i] = 1;
            else if (hit && s == 2 && wdata[4])   m_ip[i] = 0;
            if (hit && s == 2) begin
               m_en[i] = wdata[0]; m_rs[i] = wdata[1]; m_ie[i] = wdata[3];
            end else if (uf && !m_rs[i]) begin
               m_en[i] = 0;
            end
         end
         if (we && addr == 0)   m_sc = wdata[15:0];
         else if (t)            m_sc = m_srl;
         else                   m_sc = m_sc - 1;
         if (we && addr == 1)   m_srl = wdata[15:0];
      end
   end

   function automatic logic [31:0] mread(input logic [5:0] a);
      int b, s;
      b = a >> 2;
      s = a & 3;
      if (b == 0) begin
         if (s == 0) return {16'h0, m_sc};
         if (s == 1) return {16'h0, m_srl};
         if (s == 2) return 32'h0000_0342;
         return 0;
      end
      if (b - 1 < NC) begin
         if (s == 0) return m_cnt[b-1];
         if (s == 1) return m_rld[b-1];
         if (s == 2) return {27'h0, m_ip[b-1], m_ie[b-1], 1'b0, m_rs[b-1], m_en[b-1]};
      end
      return 0;
   endfunction

   // per-cycle compare, before the next inputs are driven
   always @(negedge clk) begin
      if (started && rst_n) begin
         logic [31:0] e;
         e = mread(addr);
         vectors++;
         if (rdata !== e) begin
            fails++;
            $display("FAIL %s read addr %0d: got %h expected %h", cur_req, addr, rdata, e);
         end
         for (int i = 0; i < NC; i++) begin
            if (irq[i] !== m_irq[i]) begin
               fails++;
               $display("FAIL %s irq[%0d]: got %b expected %b", cur_req, i, irq[i], m_irq[i]);
            end
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic cyc(input logic [5:0] a, input logic w, input logic [31:0] d);
      @(negedge clk); #1;
      addr = a; we = w; wdata = d;
   endtask

   task automatic idle(input int n, input logic [5:0] a);
      for (int k = 0; k < n; k++) cyc(a, 1'b0, 32'h0);
   endtask

   task automatic chk_const(input logic [5:0] a, input logic [31:0] exp, input string req);
      cyc(a, 1'b0, 32'h0);
      @(negedge clk); #2;
      vectors++;
      if (rdata !== exp) begin
         fails++;
         $display("FAIL %s const read addr %0d: got %h expected %h", req, a, rdata, exp);
      end
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog: run hung, got no finish expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      started = 1;

      // R12 / R1: reset state of every mapped word
      cur_req = "R12";
      chk_const(0, 0, "R12");  chk_const(1, 0, "R12");
      chk_const(4, 0, "R12");  chk_const(5, 0, "R12");  chk_const(6, 0, "R12");
      chk_const(8, 0, "R12");  chk_const(9, 0, "R12");  chk_const(10, 0, "R12");
      cur_req = "R1";
      chk_const(2, 32'h342, "R1");

      // R10: capability word ignores writes
      cur_req = "R10";
      cyc(2, 1, 32'hFFFF_FFFF);
      chk_const(2, 32'h342, "R10");

      // R11: unmapped words read 0 and writes do nothing
      cur_req = "R11";
      cyc(3, 1, 32'h5);
      cyc(13, 1, 32'h7);
      cyc(12, 1, 32'h9);
      chk_const(3, 0, "R11");
      chk_const(13, 0, "R11");
      chk_const(12, 0, "R11");

      // R2: scaler truncation and rate
      cur_req = "R2";
      cyc(1, 1, 32'h0001_2345);
      chk_const(1, 32'h2345, "R2");
      cyc(1, 1, 32'hFFFF_0003);
      cyc(0, 1, 32'hABCD_0002);
      idle(12, 0);

      // R4 / R6: restart channel 0, reload 5, tick every 4 clocks
      cur_req = "R4";
      cyc(5, 1, 5);
      cyc(6, 1, 32'h0000_000F);
      idle(60, 4);

      // R9 / R8: config readback shows no load bit
      cur_req = "R9";
      idle(4, 6);

      // R7: pending kept on write-zero, cleared on write-one
      cur_req = "R7";
      idle(30, 6);
      cyc(6, 1, 32'h0000_000B);
      idle(2, 6);
      cyc(6, 1, 32'h0000_001B);
      idle(4, 6);

      // R3 / R5: channel 1 holds while disabled, then runs one-shot
      cur_req = "R3";
      cyc(9, 1, 0);
      cyc(8, 1, 3);
      idle(6, 8);
      cur_req = "R5";
      cyc(10, 1, 32'h0000_0009);
      idle(30, 8);
      idle(3, 10);

      // R6: interrupt enable clear -> no pending, no pulse
      cur_req = "R6";
      cyc(8, 1, 2);
      cyc(10, 1, 32'h0000_0011);
      idle(24, 10);

      // R8: counter write and load bit on channel 1
      cur_req = "R8";
      cyc(9, 1, 6);
      cyc(10, 1, 32'h0000_000E);
      idle(10, 8);
      cyc(8, 1, 1);
      idle(10, 8);

      // R2: scaler reload 0 ticks every clock
      cur_req = "R2";
      cyc(1, 1, 0);
      cyc(0, 1, 0);
      idle(30, 4);

      // random mix of writes against running channels
      cur_req = "R4";
      for (int n = 0; n < 3000; n++) begin
         logic [5:0] a;
         logic [31:0] d;
         logic w;
         a = 6'($urandom % 16);
         w = ($urandom % 10) < 3;
         d = $urandom;
         if (a == 0 || a == 1)
            d = ($urandom % 6) | (($urandom % 2) ? 32'h0001_0000 : 32'h0);
         else if ((a & 3) != 2)
            d = $urandom % 20;
         cyc(a, w, d);
      end

      idle(4, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule